// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block sits in a scan-out pixel stream and paints a 32x32 two-colour cursor over it. Each incoming pixel comes with its x/y screen coordinates and a base colour. When the pixel falls inside the cursor window, a per-row opacity bit decides whether the cursor covers it. If it does, a second per-row bit chooses one of two overlay colours. Outside the window, and wherever the cursor is transparent, the base colour passes through unchanged.

Software programs the cursor through a simple word-wide register port. The port holds a position word, 32 opacity rows and 32 colour-select rows, plus one general-purpose control word. Both overlay colours come from the palette as inputs, and the active line width is also an input. The result leaves the block one clock after the pixel enters it, with the pixel's coordinates and valid flag delayed to match.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor origin is (0xF000, 0xF000), which places it off a normal screen. The control word resets to zero.
- R2: Writing the position word at byte offset 0x8FC sets the cursor x origin from data bits 31:16 and the y origin from data bits 15:0.
- R3: Each opacity row is a 32-bit word. Row r is at byte offset 0x900 + 4r. Each colour-select row r is at byte offset 0x980 + 4r.
- R4: The window covers scan lines cur_y through cur_y+31. A pixel on line y uses row y - cur_y, and pixels on any other line pass through.
- R5: Within a row, column x - cur_x uses bit 31 - (x - cur_x), so the leftmost cursor pixel uses the most significant bit.
- R6: In the window, opacity bit 0 passes the base colour through. Opacity 1 with select bit 1 outputs color_fg. Opacity 1 with select bit 0 outputs color_bg.
- R7: Pixels with x at or beyond line_width always pass through. A cursor whose x origin is at or beyond line_width therefore draws nothing.
- R8: Reading the control word at byte offset 0x818 returns the last value written to it, with bit 25 forced to 1. Reads at every other offset, including the position and row words, return zero. reg_rdata follows reg_addr combinationally.
- R9: out_color, out_x, out_y and out_valid appear exactly one clock after the matching pixel inputs.
- R10: A register write takes effect for a pixel presented in the clock cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| line_width | input | 16 | Active pixels per line |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel line |
| pix_base | input | 24 | Input base colour |
| color_fg | input | 24 | Overlay colour for select bit 1 |
| color_bg | input | 24 | Overlay colour for select bit 0 |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_x | output | 16 | Delayed pixel column |
| out_y | output | 16 | Delayed pixel line |
| out_color | output | 24 | Resulting colour |

## Verification
Pixel results are due one rising edge after the pixel is driven. The bench drives every pixel on a falling edge and compares colour, coordinates and valid on the next falling edge, so each comparison lands in the one cycle where that pixel's result is registered. Register writes are applied on a falling edge and sampled by the next rising edge, and the following pixel goes in right after that edge, so it already sees the new state. Register reads are combinational, so they are checked a nanosecond after the address is driven, with no clock edge in between.

// File: rtl/cursor_pkg.sv
`timescale 1ns/1ps
package cursor_pkg;
    // Cursor geometry is fixed by the register layout (one word per row).
    localparam int unsigned CUR_DIM      = 32;
    localparam int unsigned CUR_IDX_W    = $clog2(CUR_DIM);
    localparam int unsigned REG_ADDR_W   = 12;
    localparam int unsigned REG_DATA_W   = 32;

    // Byte offsets whose low bits the row decoder relies on.
    localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 12'h818;
    localparam logic [REG_ADDR_W-1:0] OFS_POS  = 12'h8FC;
    localparam logic [REG_ADDR_W-1:0] OFS_OPAQ = 12'h900;
    localparam logic [REG_ADDR_W-1:0] OFS_SEL  = 12'h980;

    // Bit that always reads back set in the control word.
    localparam logic [REG_DATA_W-1:0] CTRL_FORCED = 32'h0200_0000;
endpackage

// File: rtl/cursor_regs.sv
`timescale 1ns/1ps
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int unsigned COORD_W   = 16,
    parameter int unsigned RESET_POS = 'hF000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [REG_ADDR_W-1:0]         reg_addr,
    input  logic [REG_DATA_W-1:0]         reg_wdata,
    output logic [REG_DATA_W-1:0]         reg_rdata,
    output logic [COORD_W-1:0]            cur_x,
    output logic [COORD_W-1:0]            cur_y,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] opaq_rows,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] sel_rows
);
    localparam int unsigned ROW_LSB    = 2;
    localparam int unsigned REGION_LSB = ROW_LSB + CUR_IDX_W;

    typedef struct packed {
        logic [COORD_W-1:0]              cx;
        logic [COORD_W-1:0]              cy;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] opaq;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] sel;
        logic [REG_DATA_W-1:0]           ctrl;
    } regs_t;

    regs_t s_d, s_q;

    logic                  aligned;
    logic                  hit_pos, hit_ctrl, hit_opaq, hit_sel;
    logic [CUR_IDX_W-1:0]  row_idx;

    always_comb begin
        aligned  = (reg_addr[ROW_LSB-1:0] == '0);
        hit_pos  = aligned && (reg_addr[REG_ADDR_W-1:ROW_LSB] == OFS_POS[REG_ADDR_W-1:ROW_LSB]);
        hit_ctrl = aligned && (reg_addr[REG_ADDR_W-1:ROW_LSB] == OFS_CTRL[REG_ADDR_W-1:ROW_LSB]);
        hit_opaq = aligned && (reg_addr[REG_ADDR_W-1:REGION_LSB] == OFS_OPAQ[REG_ADDR_W-1:REGION_LSB]);
        hit_sel  = aligned && (reg_addr[REG_ADDR_W-1:REGION_LSB] == OFS_SEL[REG_ADDR_W-1:REGION_LSB]);
        row_idx  = reg_addr[REGION_LSB-1:ROW_LSB];
    end

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            if (hit_pos) begin
                s_d.cx = reg_wdata[16 +: COORD_W];
                s_d.cy = reg_wdata[0 +: COORD_W];
            end else if (hit_ctrl) begin
                s_d.ctrl = reg_wdata;
            end else if (hit_opaq) begin
                s_d.opaq[row_idx] = reg_wdata[CUR_DIM-1:0];
            end else if (hit_sel) begin
                s_d.sel[row_idx] = reg_wdata[CUR_DIM-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cx   <= COORD_W'(RESET_POS);
            s_q.cy   <= COORD_W'(RESET_POS);
            s_q.opaq <= '0;
            s_q.sel  <= '0;
            s_q.ctrl <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) reg_rdata = s_q.ctrl | CTRL_FORCED;
    end

    assign cur_x     = s_q.cx;
    assign cur_y     = s_q.cy;
    assign opaq_rows = s_q.opaq;
    assign sel_rows  = s_q.sel;

    // R2: a position write lands in the origin registers one edge later.
    a_r2_pos_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_POS) |=>
            (cur_x == $past(reg_wdata[16 +: COORD_W]) && cur_y == $past(reg_wdata[0 +: COORD_W])));

    // R8: the control word never reads back with bit 25 clear.
    a_r8_ctrl_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTRL) |-> reg_rdata[25]);

    // R8: the position word reads as zero.
    a_r8_pos_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_POS) |-> (reg_rdata == '0));
endmodule

// File: rtl/cursor_hit.sv
`timescale 1ns/1ps
module cursor_hit
    import cursor_pkg::*;
#(
    parameter int unsigned COORD_W = 16
) (
    input  logic [COORD_W-1:0]              pix_x,
    input  logic [COORD_W-1:0]              pix_y,
    input  logic [COORD_W-1:0]              cur_x,
    input  logic [COORD_W-1:0]              cur_y,
    input  logic [COORD_W-1:0]              line_width,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] opaq_rows,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] sel_rows,
    output logic                            hit,
    output logic                            sel_fg
);
    localparam int unsigned DW = COORD_W + 1;

    logic [DW-1:0]        dx, dy;
    logic                 in_x, in_y;
    logic [CUR_IDX_W-1:0] row, col;
    logic [CUR_DIM-1:0]   opaq_row, sel_row;

    always_comb begin
        dx   = {1'b0, pix_x} - {1'b0, cur_x};
        dy   = {1'b0, pix_y} - {1'b0, cur_y};
        // Horizontal window, clipped at the active width.
        in_x = (pix_x >= cur_x) && (dx < DW'(CUR_DIM)) && (pix_x < line_width);
        in_y = (pix_y >= cur_y) && (dy < DW'(CUR_DIM));
        row  = dy[CUR_IDX_W-1:0];
        // Leftmost cursor column takes the most significant row bit.
        col  = CUR_IDX_W'(CUR_DIM - 1) - dx[CUR_IDX_W-1:0];
        opaq_row = opaq_rows[row];
        sel_row  = sel_rows[row];
        hit    = in_x && in_y && opaq_row[col];
        sel_fg = sel_row[col];
    end
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int unsigned COORD_W = 16,
    parameter int unsigned COLOR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic [COORD_W-1:0]    line_width,
    input  logic                  pix_valid,
    input  logic [COORD_W-1:0]    pix_x,
    input  logic [COORD_W-1:0]    pix_y,
    input  logic [COLOR_W-1:0]    pix_base,
    input  logic [COLOR_W-1:0]    color_fg,
    input  logic [COLOR_W-1:0]    color_bg,
    output logic                  out_valid,
    output logic [COORD_W-1:0]    out_x,
    output logic [COORD_W-1:0]    out_y,
    output logic [COLOR_W-1:0]    out_color
);
    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [COLOR_W-1:0] color;
    } pipe_t;

    logic [COORD_W-1:0]              cur_x, cur_y;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] opaq_rows, sel_rows;
    logic                            hit, sel_fg;
    pipe_t                           p_d, p_q;

    cursor_regs #(.COORD_W(COORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .opaq_rows (opaq_rows),
        .sel_rows  (sel_rows)
    );

    cursor_hit #(.COORD_W(COORD_W)) u_hit (
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .line_width (line_width),
        .opaq_rows  (opaq_rows),
        .sel_rows   (sel_rows),
        .hit        (hit),
        .sel_fg     (sel_fg)
    );

    always_comb begin
        p_d.valid = pix_valid;
        p_d.x     = pix_x;
        p_d.y     = pix_y;
        if (hit) p_d.color = sel_fg ? color_fg : color_bg;
        else     p_d.color = pix_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.valid;
    assign out_x     = p_q.x;
    assign out_y     = p_q.y;
    assign out_color = p_q.color;

    // R9: the qualifier follows the input one clock later.
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    a_r9_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R7: pixels past the active width keep their base colour.
    a_r7_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x >= line_width) |=> (out_color == $past(pix_base)));

    // R4: lines above the cursor origin keep their base colour.
    a_r4_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_y < cur_y) |=> (out_color == $past(pix_base)));

    // R6: an opaque pixel with select set shows the foreground colour.
    a_r6_fg: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel_fg) |=> (out_color == $past(color_fg)));
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
    localparam logic [23:0] FG = 24'hFF00FF;
    localparam logic [23:0] BG = 24'h00FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] line_width = 16'd64;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_base = '0;
    logic        out_valid;
    logic [15:0] out_x, out_y;
    logic [23:0] out_color;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int          cx, cy, wid;
    logic [31:0] opaq_m [32];
    logic [31:0] sel_m  [32];

    always #4 clk = ~clk;

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_width(line_width),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_base(pix_base),
        .color_fg(FG), .color_bg(BG), .out_valid(out_valid), .out_x(out_x),
        .out_y(out_y), .out_color(out_color)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] base_of(int x, int y);
        return {x[7:0] ^ 8'h3C, y[7:0], 8'hA5};
    endfunction

    function automatic logic [23:0] expect_color(int x, int y);
        int r, c;
        if (y >= cy && y < cy + 32 && x >= cx && x < cx + 32 && x < wid) begin
            r = y - cy;
            c = x - cx;
            if (opaq_m[r][31 - c]) return sel_m[r][31 - c] ? FG : BG;
        end
        return base_of(x, y);
    endfunction

    // Called on a falling edge; checks the result on the next falling edge.
    task automatic pix(int x, int y, bit v, string req);
        pix_valid = v;
        pix_x     = 16'(x);
        pix_y     = 16'(y);
        pix_base  = base_of(x, y);
        @(posedge clk);
        @(negedge clk);
        check(req, {40'd0, out_color}, {40'd0, expect_color(x, y)});
        check("R9", {31'd0, out_valid, out_x, out_y}, {31'd0, v, 16'(x), 16'(y)});
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 12'h8FC) begin
            cx = int'(d[31:16]);
            cy = int'(d[15:0]);
        end else if (a >= 12'h900 && a < 12'h980) opaq_m[(a - 12'h900) >> 2] = d;
        else if (a >= 12'h980 && a < 12'hA00)     sel_m[(a - 12'h980) >> 2]  = d;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #1;
        check(req, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic load_rows(int seed);
        for (int i = 0; i < 32; i++) begin
            wr(12'h900 + 12'(4 * i), 32'hF0E1D2C3 ^ (32'h01234567 * (i + seed)));
            wr(12'h980 + 12'(4 * i), 32'h5A5A5A5A ^ (32'h11111111 * i));
        end
    endtask

    task automatic set_width(int w);
        line_width = 16'(w);
        wid        = w;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cx = 'hF000;
        cy = 'hF000;
        wid = 64;
        for (int i = 0; i < 32; i++) begin
            opaq_m[i] = '0;
            sel_m[i]  = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R8: reset values seen through the ports.
        rd(12'h818, 32'h0200_0000, "R1/R8 ctrl reset");
        rd(12'h8FC, 32'h0, "R8 pos reads zero");
        set_width(16'hFFFF);
        for (int i = 0; i < 32; i++) wr(12'h900 + 12'(4 * i), 32'hFFFF_FFFF);
        pix('hF000, 'hF000, 1'b1, "R1 origin corner");
        pix('hEFFF, 'hF000, 1'b1, "R1 left of origin");
        pix('hF01F, 'hF01F, 1'b1, "R1 far corner");
        pix('hF020, 'hF000, 1'b1, "R1 right of window");
        pix('hF000, 'hF020, 1'b1, "R1 below window");
        pix(10, 10, 1'b1, "R1 on screen untouched");

        // R8: control word readback and non-readable words.
        wr(12'h818, 32'h0000_00FF);
        rd(12'h818, 32'h0200_00FF, "R8 ctrl bit25 forced");
        wr(12'h818, 32'hFFFF_FFFF);
        rd(12'h818, 32'hFFFF_FFFF, "R8 ctrl all ones");
        wr(12'h818, 32'h0);
        rd(12'h818, 32'h0200_0000, "R8 ctrl zero");
        rd(12'h900, 32'h0, "R8 opaque row reads zero");
        rd(12'h9FC, 32'h0, "R8 select row reads zero");
        rd(12'h400, 32'h0, "R8 unmapped reads zero");

        // R2/R3/R4/R5/R6/R10: full sweep around a placed cursor.
        set_width(64);
        load_rows(1);
        wr(12'h8FC, {16'd5, 16'd3});
        for (int y = 0; y <= 36; y++)
            for (int x = 0; x <= 40; x++)
                pix(x, y, 1'b1, "R4/R5/R6 sweep");

        // R5: single-bit rows pin the column order.
        wr(12'h8FC, {16'd0, 16'd0});
        wr(12'h900, 32'h8000_0000);
        wr(12'h980, 32'h8000_0000);
        wr(12'h904, 32'h0000_0001);
        wr(12'h984, 32'h0000_0000);
        for (int x = 0; x <= 33; x++) begin
            pix(x, 0, 1'b1, "R5 msb first");
            pix(x, 1, 1'b1, "R5 lsb last");
        end

        // R3: every row offset addressed directly.
        load_rows(7);
        for (int y = 0; y <= 33; y++)
            for (int x = 0; x <= 33; x++)
                pix(x, y, 1'b1, "R3 row offsets");

        // R7: right-edge clipping.
        wr(12'h8FC, {16'd50, 16'd10});
        for (int y = 8; y <= 44; y++)
            for (int x = 45; x <= 66; x++)
                pix(x, y, 1'b1, "R7 clip at width");
        wr(12'h8FC, {16'd64, 16'd0});
        for (int y = 0; y <= 3; y++)
            for (int x = 58; x <= 70; x++)
                pix(x, y, 1'b1, "R7 origin at width");

        // R9: idle cycles carry an inactive qualifier.
        pix(3, 3, 1'b0, "R9 idle pixel");
        pix(4, 3, 1'b1, "R9 active after idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule